// File: doc/BRIEF.md
# Per-Row Fault Bitmap Remap Controller

This block sits beside a cache whose rows each hold several blocks. It keeps one fault bit for every cache block, grouped into one word per cache row, and reads the word for the row of each access. From that word and the requested column it works out the column that must really be used. A healthy block is used as requested. A faulty block is steered to a healthy neighbour in the same row, so the cache shrinks at block granularity while the address seen by the processor stays unchanged.

After a self-test, the fault words are written through a configuration port, one row per write. A row in which every block is faulty cannot be repaired. Writing such a row clears a sticky chip-usable status, and any access to such a row returns an error flag. A new load session is opened with a one-cycle begin pulse, which sets the status back to usable. Every row must be written before it is accessed.

Replacement spreads the faulty blocks over the survivors by ordinal pairing, counting columns from 0 upward. The k-th faulty block of a row (k counted from 0) is sent to the healthy block whose ordinal is k modulo the number of healthy blocks. With four blocks this sends a lone faulty block to the lowest healthy column. Two faulty blocks go in order to the two healthy ones, and three faulty blocks all go to the one survivor.

Top module: `fault_remap_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` is 0 and `chip_ok` is 1.
- R2: An access presented with `acc_valid` high gives exactly one response with `rsp_valid` high two clock edges later, carrying the same row.
- R3: When the fault bit of the requested column is 0 (bit i of a word belongs to column i), `rsp_col` equals the requested column, `rsp_moved` is 0 and `rsp_dead` is 0.
- R4: With exactly one fault bit set in the row word and that column requested, `rsp_col` is the lowest-numbered column whose bit is 0, and `rsp_moved` is 1.
- R5: With exactly two fault bits set, the lower faulty column maps to the lower healthy column and the higher faulty column to the higher healthy column, with `rsp_moved` 1.
- R6: With exactly three fault bits set, every faulty column maps to the single healthy column, with `rsp_moved` 1.
- R7: With all bits of the row word set, the response has `rsp_dead` 1, `rsp_moved` 0 and `rsp_col` equal to the requested column.
- R8: A configuration write of an all-ones word drives `chip_ok` to 0 from the next edge. It stays 0 through later writes of other words until a `cfg_begin` pulse, which sets it to 1.
- R9: When `cfg_begin` and an all-ones write fall in the same cycle, the write wins and `chip_ok` becomes 0.
- R10: When an access and a configuration write target the same row in the same cycle, the response is computed from the newly written word. A write to a different row in that cycle leaves the response unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_begin | input | 1 | One-cycle pulse that opens a new bitmap load and sets the status to usable |
| cfg_we | input | 1 | Write one row word of the bitmap |
| cfg_row | input | ROW_W | Row written by `cfg_we` |
| cfg_bits | input | NCOL | Fault bits of that row, bit i for column i, 1 = faulty |
| acc_valid | input | 1 | An access is presented |
| acc_row | input | ROW_W | Row part of the access index |
| acc_col | input | COL_W | Requested column |
| rsp_valid | output | 1 | Response for the access of two cycles earlier |
| rsp_row | output | ROW_W | Row of that access |
| rsp_col | output | COL_W | Column to actually use |
| rsp_moved | output | 1 | The requested column was replaced |
| rsp_dead | output | 1 | The row has no healthy block (error) |
| chip_ok | output | 1 | Sticky usable status of the loaded bitmap |

## Verification
Two pairs of functions can collide in one cycle. The first is a configuration write and an access to the same row. The second is the begin pulse and an all-ones write. The bench provokes the first by driving an access and a write of a new word to the same row in one cycle, and judges the response against the new word. It also repeats that stimulus with the write aimed at a different row and expects the old word to govern. It provokes the second by raising `cfg_begin` together with an all-ones write, and then expects `chip_ok` low on the following cycle.

// File: rtl/frc_pkg.sv
package frc_pkg;
  // default geometry: cache rows and blocks per row
  localparam int DEF_ROWS = 64;
  localparam int DEF_NCOL = 4;

  // response record handed from the remap stage to the output stage
  typedef struct packed {
    logic moved;
    logic dead;
  } frc_flags_t;
endpackage

// File: rtl/frc_bitmap.sv
module frc_bitmap #(
  parameter int ROWS = 64,
  parameter int NCOL = 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ROW_W-1:0] wrow,
  input  logic [NCOL-1:0]  wdata,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] rrow,
  output logic [NCOL-1:0]  rd_word
);
  logic [NCOL-1:0] mem [ROWS];
  logic [NCOL-1:0] rd_next;
  logic            fwd;

  // write port, no reset on storage
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wrow] <= wdata;
    end
  end

  // read with write-through forwarding for the same row
  always_comb begin
    fwd     = we && (wrow == rrow);
    rd_next = fwd ? wdata : mem[rrow];
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_word <= rd_next;
    end
  end

  // R10
  fwd_new_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && we && (wrow == rrow)) |=> (rd_word == $past(wdata)));
endmodule

// File: rtl/frc_remap.sv
module frc_remap #(
  parameter int NCOL = 4,
  localparam int COL_W = $clog2(NCOL),
  localparam int CNT_W = $clog2(NCOL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic [NCOL-1:0]  word,
  input  logic [COL_W-1:0] col,
  output logic [COL_W-1:0] phys,
  output frc_pkg::frc_flags_t flags
);
  logic [CNT_W-1:0] rank;
  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] tgt;
  logic [CNT_W-1:0] ord;
  logic [COL_W-1:0] pick;
  logic             hit;
  logic             dead;
  logic             moved;

  always_comb begin
    // ordinal of the requested column among faulty ones, and survivor count
    rank = '0;
    hcnt = '0;
    for (int j = 0; j < NCOL; j++) begin
      if (word[j]) begin
        if (j < int'(col)) rank = rank + CNT_W'(1);
      end else begin
        hcnt = hcnt + CNT_W'(1);
      end
    end
    // wrap the ordinal over the survivors
    tgt = rank;
    for (int i = 0; i < NCOL; i++) begin
      if ((hcnt != '0) && (tgt >= hcnt)) tgt = tgt - hcnt;
    end
    // locate the survivor with that ordinal
    ord  = '0;
    pick = col;
    hit  = 1'b0;
    for (int j = 0; j < NCOL; j++) begin
      if (!word[j]) begin
        if (!hit && (ord == tgt)) begin
          pick = COL_W'(j);
          hit  = 1'b1;
        end
        ord = ord + CNT_W'(1);
      end
    end
    dead  = &word;
    moved = word[col] && !dead;
    phys  = moved ? pick : col;
    flags.moved = moved;
    flags.dead  = dead;
  end

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !word[col]) |-> ((phys == col) && !flags.moved && !flags.dead));
  // R4
  target_healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !flags.dead) |-> !word[phys]);
  // R7
  dead_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && (&word)) |-> (flags.dead && !flags.moved && (phys == col)));
endmodule

// File: rtl/frc_status.sv
module frc_status #(
  parameter int NCOL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_begin,
  input  logic            cfg_we,
  input  logic [NCOL-1:0] cfg_bits,
  output logic            chip_ok
);
  logic ok_next;
  logic bad_write;

  always_comb begin
    bad_write = cfg_we && (&cfg_bits);
    ok_next   = chip_ok;
    if (bad_write) begin
      ok_next = 1'b0;
    end else if (cfg_begin) begin
      ok_next = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_ok <= 1'b1;
    end else begin
      chip_ok <= ok_next;
    end
  end

  // R8
  bad_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (&cfg_bits)) |=> !chip_ok);
  // R8
  sticky_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_ok && !cfg_begin) |=> !chip_ok);
endmodule

// File: rtl/fault_remap_ctrl.sv
module fault_remap_ctrl #(
  parameter int ROWS = frc_pkg::DEF_ROWS,
  parameter int NCOL = frc_pkg::DEF_NCOL,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(NCOL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_begin,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic [NCOL-1:0]  cfg_bits,
  input  logic             acc_valid,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [COL_W-1:0] acc_col,
  output logic             rsp_valid,
  output logic [ROW_W-1:0] rsp_row,
  output logic [COL_W-1:0] rsp_col,
  output logic             rsp_moved,
  output logic             rsp_dead,
  output logic             chip_ok
);
  // stage 1: request captured alongside the bitmap read
  logic             s1_valid;
  logic [ROW_W-1:0] s1_row;
  logic [COL_W-1:0] s1_col;
  logic [NCOL-1:0]  s1_word;
  logic [COL_W-1:0] s1_phys;
  frc_pkg::frc_flags_t s1_flags;

  logic             s1_valid_nx;
  logic             rsp_valid_nx;

  frc_bitmap #(.ROWS(ROWS), .NCOL(NCOL)) u_bitmap (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wrow    (cfg_row),
    .wdata   (cfg_bits),
    .rd_en   (acc_valid),
    .rrow    (acc_row),
    .rd_word (s1_word)
  );

  frc_remap #(.NCOL(NCOL)) u_remap (
    .clk    (clk),
    .rst_n  (rst_n),
    .chk_en (s1_valid),
    .word   (s1_word),
    .col    (s1_col),
    .phys   (s1_phys),
    .flags  (s1_flags)
  );

  frc_status #(.NCOL(NCOL)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_begin (cfg_begin),
    .cfg_we    (cfg_we),
    .cfg_bits  (cfg_bits),
    .chip_ok   (chip_ok)
  );

  always_comb begin
    s1_valid_nx  = acc_valid;
    rsp_valid_nx = s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      s1_valid  <= s1_valid_nx;
      rsp_valid <= rsp_valid_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_valid) begin
      s1_row <= acc_row;
      s1_col <= acc_col;
    end
    if (s1_valid) begin
      rsp_row   <= s1_row;
      rsp_col   <= s1_phys;
      rsp_moved <= s1_flags.moved;
      rsp_dead  <= s1_flags.dead;
    end
  end

  // R2
  stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> s1_valid);
  // R2
  response_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (rsp_valid && (rsp_row == $past(s1_row))));
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !rsp_valid);
endmodule

// File: tb/fault_remap_ctrl_test.sv
module fault_remap_ctrl_test;
  localparam int ROWS = 64;
  localparam int NCOL = 4;
  localparam int ROW_W = 6;
  localparam int COL_W = 2;

  logic             clk;
  logic             rst_n;
  logic             cfg_begin;
  logic             cfg_we;
  logic [ROW_W-1:0] cfg_row;
  logic [NCOL-1:0]  cfg_bits;
  logic             acc_valid;
  logic [ROW_W-1:0] acc_row;
  logic [COL_W-1:0] acc_col;
  logic             rsp_valid;
  logic [ROW_W-1:0] rsp_row;
  logic [COL_W-1:0] rsp_col;
  logic             rsp_moved;
  logic             rsp_dead;
  logic             chip_ok;

  fault_remap_ctrl #(.ROWS(ROWS), .NCOL(NCOL)) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             moved;
    logic             dead;
    string            tag;
  } item_t;

  item_t exp_q[$];
  logic [NCOL-1:0] shadow [ROWS];

  // expectation from the requirements: k-th faulty to survivor k mod count
  function automatic item_t model(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                                  input logic [NCOL-1:0] w);
    item_t it;
    int healthy[NCOL];
    int nh = 0;
    int nf = 0;
    int k = 0;
    for (int j = 0; j < NCOL; j++) begin
      if (!w[j]) begin healthy[nh] = j; nh++; end
      else begin nf++; if (j < int'(c)) k++; end
    end
    it.row = r; it.col = c; it.moved = 1'b0; it.dead = 1'b0;
    if (nh == 0) begin
      it.dead = 1'b1; it.tag = "R7";
    end else if (!w[c]) begin
      it.tag = "R3";
    end else begin
      it.col = COL_W'(healthy[k % nh]); it.moved = 1'b1;
      it.tag = (nf == 1) ? "R4" : (nf == 2) ? "R5" : "R6";
    end
    return it;
  endfunction

  task automatic idle();
    cfg_begin = 1'b0; cfg_we = 1'b0; acc_valid = 1'b0;
  endtask

  // one cycle: optional write, optional begin, optional access
  task automatic step(input bit do_wr, input logic [ROW_W-1:0] wr,
                      input logic [NCOL-1:0] wb, input bit do_beg,
                      input bit do_acc, input logic [ROW_W-1:0] ar,
                      input logic [COL_W-1:0] ac, input string tag_ovr);
    item_t it;
    @(negedge clk);
    cfg_we = do_wr; cfg_row = wr; cfg_bits = wb; cfg_begin = do_beg;
    acc_valid = do_acc; acc_row = ar; acc_col = ac;
    if (do_wr) shadow[wr] = wb;
    if (do_acc) begin
      it = model(ar, ac, shadow[ar]);
      if (tag_ovr != "") it.tag = tag_ovr;
      exp_q.push_back(it);
    end
  endtask

  task automatic check_ok(input logic exp, input string tag);
    @(negedge clk);
    idle();
    checks++;
    if (chip_ok !== exp) begin
      errors++;
      $display("FAIL %s chip_ok actual=%b expected=%b", tag, chip_ok, exp);
    end
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      item_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response actual=row %0d expected=none", rsp_row);
      end else begin
        e = exp_q.pop_front();
        if (rsp_row !== e.row || rsp_col !== e.col || rsp_moved !== e.moved || rsp_dead !== e.dead) begin
          errors++;
          $display("FAIL %s row %0d actual=col %0d moved %b dead %b expected=col %0d moved %b dead %b",
                   e.tag, e.row, rsp_col, rsp_moved, rsp_dead, e.col, e.moved, e.dead);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); cfg_row = '0; cfg_bits = '0; acc_row = '0; acc_col = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    checks++;
    if (rsp_valid !== 1'b0 || chip_ok !== 1'b1) begin
      errors++;
      $display("FAIL R1 actual=valid %b ok %b expected=valid 0 ok 1", rsp_valid, chip_ok);
    end
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || chip_ok !== 1'b1) begin
      errors++;
      $display("FAIL R1 after release actual=valid %b ok %b expected=valid 0 ok 1", rsp_valid, chip_ok);
    end

    // load every row with a repairable word (0..14)
    step(0, '0, '0, 1, 0, '0, '0, "");
    for (int r = 0; r < ROWS; r++) step(1, ROW_W'(r), NCOL'(r % 15), 0, 0, '0, '0, "");
    check_ok(1'b1, "R8");

    // every row and column back to back (R3 R4 R5 R6, latency R2)
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < NCOL; c++) step(0, '0, '0, 0, 1, ROW_W'(r), COL_W'(c), "");
    repeat (3) begin @(negedge clk); idle(); end

    // R7 and R8: dead row clears status
    step(1, 6'd5, 4'hF, 0, 0, '0, '0, "");
    check_ok(1'b0, "R8");
    for (int c = 0; c < NCOL; c++) step(0, '0, '0, 0, 1, 6'd5, COL_W'(c), "R7");
    step(1, 6'd5, 4'h0, 0, 0, '0, '0, "");
    check_ok(1'b0, "R8 sticky");
    step(0, '0, '0, 1, 0, '0, '0, "");
    check_ok(1'b1, "R8 begin");

    // R9: begin and bad write together
    step(1, 6'd9, 4'hF, 1, 0, '0, '0, "");
    check_ok(1'b0, "R9");
    step(1, 6'd9, 4'h2, 1, 0, '0, '0, "");
    check_ok(1'b1, "R9 restore");

    // R10: same-row write and access in one cycle
    step(1, 6'd7, 4'b0101, 0, 1, 6'd7, 2'd2, "R10");
    step(1, 6'd7, 4'b1110, 0, 1, 6'd7, 2'd3, "R10");
    step(1, 6'd7, 4'b0000, 0, 1, 6'd7, 2'd1, "R10");
    // R10: other-row write leaves this row's word
    step(1, 6'd9, 4'b1111, 0, 1, 6'd8, 2'd0, "R10");
    step(1, 6'd9, 4'b0000, 0, 1, 6'd8, 2'd3, "R10");
    repeat (4) begin @(negedge clk); idle(); end

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule